// File: doc/BRIEF.md
# Multi-Thread Gate Control Sequencer

This block sets which traffic classes may transmit on each egress port. It reads from one shared table of timed entries. Each entry carries three things: a duration in ticks, a mask of the traffic classes to close, and the set of ports the entry applies to. Up to eight execution threads run over this table. Each thread loops over its own contiguous slice, which starts at a programmable entry address and ends at that thread's end index. The first slice entry follows the end entry, so the thread repeats its slice forever.

A tick counter advances on each tick pulse while the block is enabled. A thread starts when this counter reaches a common base time plus the thread's own offset. The block combines the open-gate vectors of all running threads into one vector per port. Software loads every table while the block is disabled and then raises the enable. To change a running schedule, software disables the block, rewrites the tables and enables it again.

Top module: `gate_sched_seq`

## Requirements
- R1: After reset and on the clock after any cycle with enable low, every bit of the gate output is 1 (all gates open).
- R2: Thread t begins the first clock after the tick count is at least base time plus offset[t]. Until then it has no effect on any port. The tick count is 0 at the moment enable rises.
- R3: A running thread steps through the table from its start address up to its end index, inclusive. After the end index it returns to its start address.
- R4: The tick count rises by one for each tick pulse seen while enabled, and is held at 0 while disabled. The current entry stays in force for exactly its duration in ticks.
- R5: A table entry word has the duration in bits [18:0], the close mask in bits [26:19] and the destination ports in bits [31:27]. For each destination port, the entry opens the classes given by the inverted mask. Output bit p*8+c is class c of port p.
- R6: A table write whose duration field is zero is dropped, and the entry keeps its previous contents.
- R7: A base-time write of zero is dropped, and the previous base time stays.
- R8: Only threads 0 to N run, where N is the active-count register (number of threads minus one). Threads above N hold no gates closed.
- R9: When more than one running thread drives the same port, that port's vector is the bitwise AND of their open vectors.
- R10: Configuration writes made while enabled are dropped, and the running schedule goes on unchanged.
- R11: The end indices must not decrease from thread 0 to thread 7.
- R12: Write selects: 0 selects the table (address = entry). 1 selects the thread entry point (address = thread, offset in bits [15:0], start address from bit 16). 2 selects the end index (address = thread, index in the low bits). 3 selects the globals (address 0 = base time, address 1 = active count in bits [2:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the schedule; low clears the tick count and stops all threads |
| tick_i | input | 1 | One-cycle pulse for each tick |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Selects which table the write goes to |
| cfg_addr_i | input | ADDR_W (4) | Entry or thread index |
| cfg_wdata_i | input | 32 | Write data |
| gate_open_o | output | NUM_PORTS*NUM_TC (40) | Open-gate vector for each port |

## Verification
Two threads run with different slice lengths and offsets, and both drive one shared port. This pattern separates correct wrapping and per-entry duration from off-by-one stepping, and it separates the AND merge from a last-writer merge. A third thread's table slice is set up but left outside the active count. The run is then repeated with that thread included. This shows whether the count gates the thread or the table alone does.

A zero-duration write, a zero base write and writes made while running are placed so that, if any of them were accepted, the gate pattern or the start tick would visibly change. A disable and re-enable, with a tick sent while disabled, shows whether the tick count restarts at zero.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY  = 2'd0,
    SEL_EPOINT = 2'd1,
    SEL_ENDIDX = 2'd2,
    SEL_GLOBAL = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    TH_IDLE = 1'b0,
    TH_RUN  = 1'b1
  } thr_state_e;

  localparam int unsigned CFG_W     = 32;
  localparam int unsigned EP_ADDR_LSB = 16;
endpackage

// File: rtl/gss_cfg_store.sv
module gss_cfg_store
  import gss_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned NUM_TC      = 8,
  parameter int unsigned TBL_DEPTH   = 16,
  parameter int unsigned DELTA_W     = 19,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned OFF_W       = 16,
  localparam int unsigned ADDR_W     = $clog2(TBL_DEPTH),
  localparam int unsigned THR_W      = $clog2(NUM_THREADS)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   enable_i,
  input  logic                                   cfg_we_i,
  input  logic [1:0]                             cfg_sel_i,
  input  logic [ADDR_W-1:0]                      cfg_addr_i,
  input  logic [CFG_W-1:0]                       cfg_wdata_i,
  output logic [TBL_DEPTH-1:0][DELTA_W-1:0]      tbl_delta_o,
  output logic [TBL_DEPTH-1:0][NUM_TC-1:0]       tbl_mask_o,
  output logic [TBL_DEPTH-1:0][NUM_PORTS-1:0]    tbl_ports_o,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]     ep_addr_o,
  output logic [NUM_THREADS-1:0][OFF_W-1:0]      ep_off_o,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]     end_idx_o,
  output logic [TIME_W-1:0]                      base_o,
  output logic [THR_W-1:0]                       act_o
);
  localparam int unsigned MASK_LSB  = DELTA_W;
  localparam int unsigned PORTS_LSB = DELTA_W + NUM_TC;

  logic                   wr_ok;
  logic                   ent_we, ep_we, end_we, base_we, act_we;
  logic [DELTA_W-1:0]     wr_delta;
  logic [NUM_TC-1:0]      wr_mask;
  logic [NUM_PORTS-1:0]   wr_ports;
  logic [THR_W-1:0]       wr_thr;

  logic [TBL_DEPTH-1:0][DELTA_W-1:0]   delta_q;
  logic [TBL_DEPTH-1:0][NUM_TC-1:0]    mask_q;
  logic [TBL_DEPTH-1:0][NUM_PORTS-1:0] ports_q;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  ep_addr_q;
  logic [NUM_THREADS-1:0][OFF_W-1:0]   ep_off_q;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  end_q;
  logic [TIME_W-1:0]                   base_q;
  logic [THR_W-1:0]                    act_q;

  // Write decode: every write is refused while the schedule runs
  always_comb begin
    wr_ok    = cfg_we_i && !enable_i;
    wr_delta = cfg_wdata_i[DELTA_W-1:0];
    wr_mask  = cfg_wdata_i[MASK_LSB +: NUM_TC];
    wr_ports = cfg_wdata_i[PORTS_LSB +: NUM_PORTS];
    wr_thr   = cfg_addr_i[THR_W-1:0];
    ent_we   = wr_ok && (cfg_sel_i == SEL_ENTRY) && (wr_delta != '0);
    ep_we    = wr_ok && (cfg_sel_i == SEL_EPOINT);
    end_we   = wr_ok && (cfg_sel_i == SEL_ENDIDX);
    base_we  = wr_ok && (cfg_sel_i == SEL_GLOBAL) && (cfg_addr_i == ADDR_W'(0))
               && (cfg_wdata_i[TIME_W-1:0] != '0);
    act_we   = wr_ok && (cfg_sel_i == SEL_GLOBAL) && (cfg_addr_i == ADDR_W'(1));
  end

  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        delta_q[e] <= DELTA_W'(1);
        mask_q[e]  <= '0;
        ports_q[e] <= '0;
      end else if (ent_we && (cfg_addr_i == ADDR_W'(e))) begin
        delta_q[e] <= wr_delta;
        mask_q[e]  <= wr_mask;
        ports_q[e] <= wr_ports;
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ep_addr_q[t] <= '0;
        ep_off_q[t]  <= '0;
      end else if (ep_we && (wr_thr == THR_W'(t))) begin
        ep_addr_q[t] <= cfg_wdata_i[EP_ADDR_LSB +: ADDR_W];
        ep_off_q[t]  <= cfg_wdata_i[OFF_W-1:0];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        end_q[t] <= '0;
      end else if (end_we && (wr_thr == THR_W'(t))) begin
        end_q[t] <= cfg_wdata_i[ADDR_W-1:0];
      end
    end
    if (t > 0) begin : g_mono
      // R11: ordered end indices are a precondition for running
      p_end_mono_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |-> (end_q[t-1] <= end_q[t]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= TIME_W'(1);
    end else if (base_we) begin
      base_q <= cfg_wdata_i[TIME_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_we) begin
      act_q <= cfg_wdata_i[THR_W-1:0];
    end
  end

  assign tbl_delta_o = delta_q;
  assign tbl_mask_o  = mask_q;
  assign tbl_ports_o = ports_q;
  assign ep_addr_o   = ep_addr_q;
  assign ep_off_o    = ep_off_q;
  assign end_idx_o   = end_q;
  assign base_o      = base_q;
  assign act_o       = act_q;

  p_base_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q != '0);

  p_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cfg_we_i) |=> ($stable(base_q) && $stable(act_q) && $stable(delta_q)
                                && $stable(mask_q) && $stable(end_q)));

  p_zero_delta_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_sel_i == SEL_ENTRY) && (cfg_wdata_i[DELTA_W-1:0] == '0))
      |=> ($stable(delta_q) && $stable(mask_q) && $stable(ports_q)));
endmodule

// File: rtl/gss_thread.sv
module gss_thread
  import gss_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned NUM_TC    = 8,
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned DELTA_W   = 19,
  parameter int unsigned TIME_W    = 32,
  localparam int unsigned ADDR_W   = $clog2(TBL_DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic                                act_i,
  input  logic                                tick_i,
  input  logic [TIME_W-1:0]                   cnt_i,
  input  logic [TIME_W-1:0]                   start_time_i,
  input  logic [ADDR_W-1:0]                   start_addr_i,
  input  logic [ADDR_W-1:0]                   end_idx_i,
  input  logic [TBL_DEPTH-1:0][DELTA_W-1:0]   delta_tbl_i,
  input  logic [TBL_DEPTH-1:0][NUM_TC-1:0]    mask_tbl_i,
  input  logic [TBL_DEPTH-1:0][NUM_PORTS-1:0] ports_tbl_i,
  output logic                                run_o,
  output logic [NUM_TC-1:0]                   mask_o,
  output logic [NUM_PORTS-1:0]                ports_o
);
  thr_state_e          st_q, st_d;
  logic [ADDR_W-1:0]   cur_q, cur_d, nxt_idx;
  logic [DELTA_W-1:0]  rem_q, rem_d;
  logic                upd_en;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    nxt_idx = (cur_q == end_idx_i) ? start_addr_i : (cur_q + ADDR_W'(1));
    if (!en_i || !act_i) begin
      st_d = TH_IDLE;
    end else if (st_q == TH_IDLE) begin
      if (cnt_i >= start_time_i) begin
        st_d  = TH_RUN;
        cur_d = start_addr_i;
        rem_d = delta_tbl_i[start_addr_i];
      end
    end else if (tick_i) begin
      if (rem_q == DELTA_W'(1)) begin
        cur_d = nxt_idx;
        rem_d = delta_tbl_i[nxt_idx];
      end else begin
        rem_d = rem_q - DELTA_W'(1);
      end
    end
    upd_en = (st_d != st_q) || (cur_d != cur_q) || (rem_d != rem_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TH_IDLE;
      cur_q <= '0;
      rem_q <= DELTA_W'(1);
    end else if (upd_en) begin
      st_q  <= st_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

  assign run_o   = (st_q == TH_RUN);
  assign mask_o  = mask_tbl_i[cur_q];
  assign ports_o = ports_tbl_i[cur_q];

  p_rem_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TH_RUN) |-> (rem_q != '0));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == TH_RUN) && en_i && act_i && tick_i && (rem_q == DELTA_W'(1))
     && (cur_q == end_idx_i)) |=> (cur_q == $past(start_addr_i)));

  p_early_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == TH_IDLE) && (cnt_i < start_time_i)) |=> (st_q == TH_IDLE));

  p_inactive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (st_q == TH_IDLE));
endmodule

// File: rtl/gss_gate_merge.sv
module gss_gate_merge #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned NUM_TC      = 8
) (
  input  logic [NUM_THREADS-1:0]                run_i,
  input  logic [NUM_THREADS-1:0][NUM_TC-1:0]    mask_i,
  input  logic [NUM_THREADS-1:0][NUM_PORTS-1:0] ports_i,
  output logic [NUM_PORTS-1:0][NUM_TC-1:0]      open_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      open_o[p] = '1;
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (run_i[t] && ports_i[t][p]) begin
          open_o[p] = open_o[p] & ~mask_i[t];
        end
      end
    end
  end
endmodule

// File: rtl/gate_sched_seq.sv
module gate_sched_seq
  import gss_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned NUM_TC      = 8,
  parameter int unsigned TBL_DEPTH   = 16,
  parameter int unsigned DELTA_W     = 19,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned OFF_W       = 16,
  localparam int unsigned ADDR_W     = $clog2(TBL_DEPTH),
  localparam int unsigned THR_W      = $clog2(NUM_THREADS),
  localparam int unsigned GATE_W     = NUM_PORTS * NUM_TC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               tick_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [GATE_W-1:0]  gate_open_o
);
  logic [TBL_DEPTH-1:0][DELTA_W-1:0]   tbl_delta;
  logic [TBL_DEPTH-1:0][NUM_TC-1:0]    tbl_mask;
  logic [TBL_DEPTH-1:0][NUM_PORTS-1:0] tbl_ports;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  ep_addr;
  logic [NUM_THREADS-1:0][OFF_W-1:0]   ep_off;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  end_idx;
  logic [TIME_W-1:0]                   base_time;
  logic [THR_W-1:0]                    act_cnt;

  logic [TIME_W-1:0]                   cnt_q, cnt_d;
  logic [NUM_THREADS-1:0]              thr_run;
  logic [NUM_THREADS-1:0][NUM_TC-1:0]  thr_mask;
  logic [NUM_THREADS-1:0][NUM_PORTS-1:0] thr_ports;
  logic [NUM_PORTS-1:0][NUM_TC-1:0]    merged;
  logic [GATE_W-1:0]                   gate_q, gate_d;

  gss_cfg_store #(
    .NUM_THREADS(NUM_THREADS), .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC),
    .TBL_DEPTH(TBL_DEPTH), .DELTA_W(DELTA_W), .TIME_W(TIME_W), .OFF_W(OFF_W)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .tbl_delta_o (tbl_delta),
    .tbl_mask_o  (tbl_mask),
    .tbl_ports_o (tbl_ports),
    .ep_addr_o   (ep_addr),
    .ep_off_o    (ep_off),
    .end_idx_o   (end_idx),
    .base_o      (base_time),
    .act_o       (act_cnt)
  );

  // Tick counter: cleared while disabled, counts tick pulses while enabled
  always_comb begin
    if (!enable_i)   cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + TIME_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_d != cnt_q)  cnt_q <= cnt_d;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic              act_t;
    logic [TIME_W-1:0] start_t;
    assign act_t   = (THR_W'(t) <= act_cnt);
    assign start_t = base_time + TIME_W'(ep_off[t]);

    gss_thread #(
      .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC), .TBL_DEPTH(TBL_DEPTH),
      .DELTA_W(DELTA_W), .TIME_W(TIME_W)
    ) u_thr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (enable_i),
      .act_i        (act_t),
      .tick_i       (tick_i),
      .cnt_i        (cnt_q),
      .start_time_i (start_t),
      .start_addr_i (ep_addr[t]),
      .end_idx_i    (end_idx[t]),
      .delta_tbl_i  (tbl_delta),
      .mask_tbl_i   (tbl_mask),
      .ports_tbl_i  (tbl_ports),
      .run_o        (thr_run[t]),
      .mask_o       (thr_mask[t]),
      .ports_o      (thr_ports[t])
    );
  end

  gss_gate_merge #(
    .NUM_THREADS(NUM_THREADS), .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC)
  ) u_merge (
    .run_i   (thr_run),
    .mask_i  (thr_mask),
    .ports_i (thr_ports),
    .open_o  (merged)
  );

  always_comb begin
    gate_d = enable_i ? GATE_W'(merged) : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gate_q <= '1;
    else if (gate_d != gate_q) gate_q <= gate_d;
  end

  assign gate_open_o = gate_q;

  p_idle_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (gate_open_o == '1));

  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !tick_i) |=> (cnt_q == $past(cnt_q)));

  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (cnt_q == '0));
endmodule

// File: tb/tb_gate_sched_seq.sv
`timescale 1ns/1ps
module tb_gate_sched_seq;
  localparam int NP = 5;
  localparam int NC = 8;
  localparam int GW = NP * NC;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic          tick;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [3:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [GW-1:0] gate_open;

  gate_sched_seq dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .enable_i    (enable),
    .tick_i      (tick),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .gate_open_o (gate_open)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference configuration kept by the bench
  int m_delta [16];
  int m_mask  [16];
  int m_ports [16];
  int m_addr  [8];
  int m_off   [8];
  int m_end   [8];
  int m_act;
  int m_base;
  int cnt;

  int checks;
  int errors;
  bit done;

  typedef struct {
    logic [GW-1:0] exp;
    string         tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  function automatic logic [GW-1:0] model(int c);
    logic [GW-1:0] res;
    res = '1;
    for (int t = 0; t < 8; t++) begin
      if (t <= m_act && c >= m_base + m_off[t]) begin
        int total;
        int k;
        int j;
        total = 0;
        for (int e = m_addr[t]; e <= m_end[t]; e++) total += m_delta[e];
        k = (c - (m_base + m_off[t])) % total;
        j = m_addr[t];
        while (k >= m_delta[j]) begin
          k -= m_delta[j];
          j++;
        end
        for (int p = 0; p < NP; p++) begin
          if (m_ports[j][p]) res[p*NC +: NC] = res[p*NC +: NC] & ~(m_mask[j][NC-1:0]);
        end
      end
    end
    return res;
  endfunction

  // Monitor: pops expected items and compares them with the output
  initial begin
    forever begin
      sb_item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      checks++;
      if (gate_open !== it.exp) begin
        errors++;
        $display("FAIL %s: gate_open actual %h expected %h", it.tag, gate_open, it.exp);
      end
    end
  end

  task automatic push_exp(logic [GW-1:0] e, string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic cfg_write(int sel, int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel[1:0];
    cfg_addr  = addr[3:0];
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  function automatic logic [31:0] ent_word(int d, int m, int p);
    return (32'(p) << 27) | (32'(m) << 19) | 32'(d);
  endfunction

  task automatic ent_set(int e, int d, int m, int p);
    cfg_write(0, e, ent_word(d, m, p));
    m_delta[e] = d;
    m_mask[e]  = m;
    m_ports[e] = p;
  endtask

  task automatic thr_set(int t, int a, int o, int en);
    cfg_write(1, t, (32'(a) << 16) | 32'(o));
    cfg_write(2, t, 32'(en));
    m_addr[t] = a;
    m_off[t]  = o;
    m_end[t]  = en;
  endtask

  task automatic tick_check(string tag);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (enable) cnt++;
    repeat (3) @(negedge clk);
    push_exp(model(cnt), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0; cnt = 0;
    rst_n = 0; enable = 0; tick = 0;
    cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push_exp('1, "R1 reset state all open");

    // Table slices: thread0 uses 0..2, thread1 uses 3..4, thread2 uses 5
    // End indices kept non-decreasing (R11); write encodings per R12
    ent_set(0, 2, 8'h01, 5'b00011);
    ent_set(1, 1, 8'h02, 5'b00011);
    ent_set(2, 3, 8'h04, 5'b00001);
    ent_set(3, 1, 8'h10, 5'b00110);
    ent_set(4, 2, 8'h20, 5'b00100);
    ent_set(5, 1, 8'hFF, 5'b01000);
    thr_set(0, 0, 0, 2);
    thr_set(1, 3, 2, 4);
    for (int t = 2; t < 8; t++) thr_set(t, 5, 0, 5);
    cfg_write(3, 0, 32'd3); m_base = 3;
    cfg_write(3, 0, 32'd0);                       // R7: rejected, base stays 3
    cfg_write(0, 0, ent_word(0, 8'h80, 5'b11111)); // R6: rejected, entry 0 unchanged
    cfg_write(3, 1, 32'd1); m_act = 1;             // R8: threads 0 and 1 only
    repeat (2) @(negedge clk);
    push_exp('1, "R1 disabled all open");

    @(negedge clk);
    enable = 1'b1;
    cnt = 0;
    repeat (3) @(negedge clk);
    push_exp(model(0), "R2 R7 before base time");

    for (int i = 0; i < 10; i++) tick_check("R2 R3 R4 R5 R6 R8 R9 run");

    // R10: writes while enabled are dropped
    cfg_write(0, 1, ent_word(1, 8'hFF, 5'b11111));
    cfg_write(3, 1, 32'd0);
    cfg_write(1, 0, (32'd4 << 16) | 32'd0);
    for (int i = 0; i < 12; i++) tick_check("R10 R3 R4 R9 locked run");

    @(negedge clk);
    enable = 1'b0;
    cnt = 0;
    repeat (2) @(negedge clk);
    push_exp('1, "R1 disable opens all");
    tick_check("R4 tick while disabled ignored");
    push_exp('1, "R1 still open when disabled");

    cfg_write(3, 1, 32'd2); m_act = 2;             // R8: enable thread 2
    @(negedge clk);
    enable = 1'b1;
    cnt = 0;
    repeat (3) @(negedge clk);
    push_exp(model(0), "R4 count restarts at zero");
    for (int i = 0; i < 9; i++) tick_check("R8 R2 R3 third thread active");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule